// File: doc/BRIEF.md
# Strap Configuration with Management Override

This block turns board-level strap inputs into the default contents of three management-visible registers of a dual-speed Ethernet PHY. The registers are a basic control word, an ability-advertisement word and a mode word. The block also decides whether the straps or a management write port owns those registers. Five four-level straps arrive already resolved by an analog front end into a 2-bit level code each. Every strap yields two bits. One is an address bit for the PHY management address. The other is a mode bit that picks one operating option. Three two-level pins (speed/restart, duplex and link-test) and a lock pin complete the strap set.

When the lock pin is low, the straps are sampled only while the internal reset is active. After that, management writes own the registers. When the lock pin is high, the strap-derived fields follow the pins on every cycle and all writes are refused. The block also stretches the released reset pin into an internal reset of a parameterised length. A write to the software-reset bit starts the same stretch. A rising edge on the speed/restart pin requests a negotiation restart while negotiation is enabled.

All pins pass through a two-flop synchronizer before any use. The level codes are 0 (lowest), 1, 2 and 3 (highest).

Top module: `strap_cfg_ctrl`

## Requirements
- R1: Address bit i of `phy_addr` is bit 1 of the level code of strap i (1 for codes 2 and 3, 0 for codes 0 and 1). It is captured while `core_rst` is high and holds when the straps change after that.
- R2: The mode bit of a strap is 1 for codes 1 and 2 and 0 for codes 0 and 3. Each strap sets one field: strap 0 sets negotiation enable (`ctrl_reg[12]`), strap 1 sets repeater (`mode_reg[0]`), strap 2 sets symbol mode (`mode_reg[1]`) and strap 3 sets scrambler bypass (`mode_reg[2]`).
- R3: With negotiation disabled, the default speed `ctrl_reg[13]` equals the speed/restart pin, duplex `ctrl_reg[8]` equals the duplex pin, link-test disable `mode_reg[4]` equals the link-test pin and fiber select `mode_reg[3]` equals the strap 4 mode bit. With negotiation enabled, the defaults are speed 1, duplex 0, `mode_reg[4]` 0 and `mode_reg[3]` 0.
- R4: `adv_reg[4:0]` is 00001. Let m be the strap 4 mode bit and F = (not link-test pin) or duplex pin. Then bit 7 (100 half) = not m, bit 8 (100 full) = not m and F, bit 5 (10 half) = (not link-test pin) or m, and bit 6 (10 full) = bit 5 and F. All other bits are 0.
- R5: With the lock pin high and no internal reset, the strap-derived fields follow the pins three clock edges after a pin change. Every write is ignored, the software-reset bit included.
- R6: With the lock pin low and no internal reset, pin changes have no effect on the registers. A write takes effect on the edge that samples it. At address 0 the write sets bits 14:8 of `ctrl_reg`, at address 4 it sets bits 8:5 of `adv_reg`, and at address 16 it sets bits 4:0 of `mode_reg`.
- R7: A rising edge of the speed/restart pin while `ctrl_reg[12]` is 1 sets `ctrl_reg[9]`, three edges after the pin rises. The bit stays set until the internal reset or an unlocked write of 0 clears it. With `ctrl_reg[12]` at 0 the edge sets nothing.
- R8: `core_rst` and `ctrl_reg[15]` stay high while the synchronized reset pin is low. After release they fall EXT_CYCLES+2 edges after the pin rises. While they are high, all registers reload their strap defaults and bits 14, 11, 10 and 9 of `ctrl_reg` clear.
- R9: An unlocked write to address 0 with bit 15 set, outside reset, raises `core_rst` on that edge and leaves the other bits unwritten. The internal reset then runs for EXT_CYCLES cycles and reloads the defaults.
- R10: Writes during the internal reset, writes to other addresses and write data bits outside the listed fields have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_pin_n | input | 1 | Board reset pin, active low, asynchronous to clk |
| strap_lvl | input | 10 | Level codes of the five straps, strap i in bits 2i+1:2i |
| pin_fde | input | 1 | Duplex strap pin |
| pin_cfg0 | input | 1 | Speed strap, or negotiation restart edge |
| pin_cfg1 | input | 1 | Link-test strap pin |
| pin_lock | input | 1 | High: straps own the registers and writes are refused |
| wr_en | input | 1 | Management write strobe |
| wr_addr | input | 5 | Management write register address |
| wr_data | input | 16 | Management write data |
| phy_addr | output | 5 | Strap-captured management address |
| ctrl_reg | output | 16 | Control word |
| adv_reg | output | 16 | Ability advertisement word |
| mode_reg | output | 16 | Operating mode word |
| core_rst | output | 1 | Stretched internal reset, active high |

## Verification
A pin change reaches the registers on the third rising edge after it is driven. A write, or a software-reset request, shows up on the edge that samples the strobe. The internal reset falls EXT_CYCLES+2 edges after the reset pin is released. The bench model has the same synchronizer delay, the same one-edge write path and the same countdown. It is stepped on every rising edge, and all output fields are compared 1 ns after that edge. The directed checks wait at least one more edge than each of these latencies before they sample, and the reset-release check samples one edge before and one edge after the expected fall.

// File: rtl/strap_cfg_pkg.sv
`timescale 1ns/1ps
package strap_cfg_pkg;
  localparam int NUM_STRAPS = 5;
  localparam int LVL_W      = 2;
  localparam int REG_W      = 16;
  localparam int ADDR_W     = 5;

  // strap index that owns each mode option
  localparam int S_AN    = 0;
  localparam int S_RPT   = 1;
  localparam int S_SYM   = 2;
  localparam int S_SCR   = 3;
  localparam int S_MEDIA = 4;

  // control word bit positions (decoded by the management side)
  localparam int C_SWRST   = 15;
  localparam int C_LOOP    = 14;
  localparam int C_SPEED   = 13;
  localparam int C_ANEN    = 12;
  localparam int C_PDN     = 11;
  localparam int C_ISO     = 10;
  localparam int C_RESTART = 9;
  localparam int C_DUPLEX  = 8;

  // advertisement field, ability order {100F,100H,10F,10H}
  localparam int A_LO = 5;
  localparam int A_W  = 4;
  localparam logic [4:0] ADV_SELECTOR = 5'b00001;

  // mode word field width, order {no_linktest, fiber, scr_bypass, symbol, repeater}
  localparam int G_W = 5;

  typedef struct packed {
    logic           an_en;
    logic           speed;
    logic           duplex;
    logic [G_W-1:0] gcfg;
    logic [A_W-1:0] abil;
  } strap_fields_t;

  function automatic logic lvl_addr(input logic [LVL_W-1:0] code);
    return code[1];
  endfunction

  function automatic logic lvl_mode(input logic [LVL_W-1:0] code);
    return code[1] ^ code[0];
  endfunction
endpackage

// File: rtl/strap_sync.sv
`timescale 1ns/1ps
module strap_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    meta <= d;
    q    <= meta;
  end
endmodule

// File: rtl/strap_decode.sv
`timescale 1ns/1ps
module strap_decode
  import strap_cfg_pkg::*;
(
  input  logic [NUM_STRAPS*LVL_W-1:0] lvl,
  input  logic                        fde,
  input  logic                        cfg0,
  input  logic                        cfg1,
  output logic [NUM_STRAPS-1:0]       addr_o,
  output strap_fields_t               fields_o
);
  logic [NUM_STRAPS-1:0] mode;

  for (genvar i = 0; i < NUM_STRAPS; i++) begin : g_lvl
    assign addr_o[i] = lvl_addr(lvl[i*LVL_W +: LVL_W]);
    assign mode[i]   = lvl_mode(lvl[i*LVL_W +: LVL_W]);
  end

  logic an, media, full;

  always_comb begin
    an    = mode[S_AN];
    media = mode[S_MEDIA];
    full  = ~cfg1 | fde;
    fields_o.an_en  = an;
    fields_o.speed  = an ? 1'b1 : cfg0;
    fields_o.duplex = an ? 1'b0 : fde;
    fields_o.gcfg   = {an ? 1'b0 : cfg1,
                       an ? 1'b0 : media,
                       mode[S_SCR],
                       mode[S_SYM],
                       mode[S_RPT]};
    fields_o.abil   = {~media & full,
                       ~media,
                       (~cfg1 | media) & full,
                       ~cfg1 | media};
  end
endmodule

// File: rtl/strap_rst_ext.sv
`timescale 1ns/1ps
module strap_rst_ext #(
  parameter int EXT_CYCLES = 7500
) (
  input  logic clk,
  input  logic rel,
  input  logic kick,
  output logic active
);
  localparam int CW = $clog2(EXT_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(EXT_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rel || kick) cnt <= LOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/strap_cfg_ctrl.sv
`timescale 1ns/1ps
module strap_cfg_ctrl
  import strap_cfg_pkg::*;
#(
  parameter int              EXT_CYCLES = 7500,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'd0,
  parameter logic [ADDR_W-1:0] ADV_ADDR  = 5'd4,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 5'd16
) (
  input  logic                        clk,
  input  logic                        rst_pin_n,
  input  logic [NUM_STRAPS*LVL_W-1:0] strap_lvl,
  input  logic                        pin_fde,
  input  logic                        pin_cfg0,
  input  logic                        pin_cfg1,
  input  logic                        pin_lock,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [REG_W-1:0]            wr_data,
  output logic [NUM_STRAPS-1:0]       phy_addr,
  output logic [REG_W-1:0]            ctrl_reg,
  output logic [REG_W-1:0]            adv_reg,
  output logic [REG_W-1:0]            mode_reg,
  output logic                        core_rst
);
  localparam int LV_W   = NUM_STRAPS * LVL_W;
  localparam int SYNC_W = LV_W + 5;

  // pin synchronization
  logic [SYNC_W-1:0] pins_raw, pins_s;
  logic              rel_s, lock_s, cfg1_s, cfg0_s, fde_s;
  logic [LV_W-1:0]   lvl_s;

  assign pins_raw = {rst_pin_n, pin_lock, pin_cfg1, pin_cfg0, pin_fde, strap_lvl};

  strap_sync #(.W(SYNC_W)) u_sync (
    .clk (clk),
    .d   (pins_raw),
    .q   (pins_s)
  );

  assign {rel_s, lock_s, cfg1_s, cfg0_s, fde_s, lvl_s} = pins_s;

  // strap decode
  strap_fields_t         dflt;
  logic [NUM_STRAPS-1:0] addr_d;

  strap_decode u_dec (
    .lvl      (lvl_s),
    .fde      (fde_s),
    .cfg0     (cfg0_s),
    .cfg1     (cfg1_s),
    .addr_o   (addr_d),
    .fields_o (dflt)
  );

  // write qualification
  logic wr_swrst, wr_ok, sw_kick, wr_ctrl, wr_adv, wr_mode;

  assign wr_swrst = wr_data[C_SWRST];
  assign wr_ok    = wr_en & ~lock_s & ~core_rst;
  assign sw_kick  = wr_ok & (wr_addr == CTRL_ADDR) & wr_swrst;
  assign wr_ctrl  = wr_ok & (wr_addr == CTRL_ADDR) & ~wr_swrst;
  assign wr_adv   = wr_ok & (wr_addr == ADV_ADDR);
  assign wr_mode  = wr_ok & (wr_addr == MODE_ADDR);

  // reset stretch
  strap_rst_ext #(.EXT_CYCLES(EXT_CYCLES)) u_rst (
    .clk    (clk),
    .rel    (rel_s),
    .kick   (sw_kick),
    .active (core_rst)
  );

  // register state
  logic                  r_loop, r_speed, r_anen, r_pdn, r_iso, r_restart, r_duplex;
  logic [A_W-1:0]        r_adv;
  logic [G_W-1:0]        r_gcfg;
  logic [NUM_STRAPS-1:0] r_addr;
  logic                  cfg0_prev;
  logic                  restart_hit;

  assign restart_hit = r_anen & cfg0_s & ~cfg0_prev;

  always_ff @(posedge clk) begin
    cfg0_prev <= cfg0_s;
    if (core_rst) begin
      r_addr    <= addr_d;
      r_anen    <= dflt.an_en;
      r_speed   <= dflt.speed;
      r_duplex  <= dflt.duplex;
      r_adv     <= dflt.abil;
      r_gcfg    <= dflt.gcfg;
      r_loop    <= 1'b0;
      r_pdn     <= 1'b0;
      r_iso     <= 1'b0;
      r_restart <= 1'b0;
    end else begin
      if (lock_s) begin
        r_anen   <= dflt.an_en;
        r_speed  <= dflt.speed;
        r_duplex <= dflt.duplex;
        r_adv    <= dflt.abil;
        r_gcfg   <= dflt.gcfg;
      end else begin
        if (wr_ctrl) begin
          r_loop    <= wr_data[C_LOOP];
          r_speed   <= wr_data[C_SPEED];
          r_anen    <= wr_data[C_ANEN];
          r_pdn     <= wr_data[C_PDN];
          r_iso     <= wr_data[C_ISO];
          r_restart <= wr_data[C_RESTART];
          r_duplex  <= wr_data[C_DUPLEX];
        end
        if (wr_adv)  r_adv  <= wr_data[A_LO +: A_W];
        if (wr_mode) r_gcfg <= wr_data[G_W-1:0];
      end
      if (restart_hit) r_restart <= 1'b1;
    end
  end

  // output assembly
  assign phy_addr = r_addr;
  assign ctrl_reg = {core_rst, r_loop, r_speed, r_anen, r_pdn, r_iso,
                     r_restart, r_duplex, 8'h00};
  assign adv_reg  = {{(REG_W-A_LO-A_W){1'b0}}, r_adv, ADV_SELECTOR};
  assign mode_reg = {{(REG_W-G_W){1'b0}}, r_gcfg};
endmodule

// File: rtl/strap_cfg_ctrl_chk.sv
`timescale 1ns/1ps
module strap_cfg_ctrl_chk #(
  parameter logic [4:0] CTRL_ADDR = 5'd0
) (
  input logic        clk,
  input logic        rst_pin_n,
  input logic        rel_s,
  input logic        lock_s,
  input logic        cfg0_s,
  input logic        cfg0_prev,
  input logic        core_rst,
  input logic        wr_en,
  input logic [4:0]  wr_addr,
  input logic        wr_swrst,
  input logic [4:0]  phy_addr,
  input logic [15:0] ctrl_reg,
  input logic [15:0] adv_reg,
  input logic [15:0] mode_reg
);
  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (core_rst)
    1'b1 |=> $stable(phy_addr));

  // R5
  lock_nowrite_chk: assert property (@(posedge clk) disable iff (core_rst)
    lock_s |=> $stable({ctrl_reg[14], ctrl_reg[11], ctrl_reg[10]}));

  // R6
  unlocked_hold_chk: assert property (@(posedge clk) disable iff (core_rst)
    (!lock_s && !wr_en && !(cfg0_s && !cfg0_prev))
      |=> ($stable(ctrl_reg[14:0]) && $stable(adv_reg) && $stable(mode_reg)));

  // R7
  restart_edge_chk: assert property (@(posedge clk) disable iff (core_rst)
    (ctrl_reg[12] && cfg0_s && !cfg0_prev) |=> ctrl_reg[9]);

  // R8
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(ctrl_reg[15]) |-> $past(rel_s));

  // R9
  sw_kick_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (wr_en && !lock_s && !core_rst && wr_addr == CTRL_ADDR && wr_swrst) |=> core_rst);
endmodule

bind strap_cfg_ctrl strap_cfg_ctrl_chk u_chk (
  .clk       (clk),
  .rst_pin_n (rst_pin_n),
  .rel_s     (rel_s),
  .lock_s    (lock_s),
  .cfg0_s    (cfg0_s),
  .cfg0_prev (cfg0_prev),
  .core_rst  (core_rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_swrst  (wr_swrst),
  .phy_addr  (phy_addr),
  .ctrl_reg  (ctrl_reg),
  .adv_reg   (adv_reg),
  .mode_reg  (mode_reg)
);

// File: tb/strap_cfg_ctrl_test.sv
`timescale 1ns/1ps
module strap_cfg_ctrl_test;
  localparam int EXT = 12;

  logic        clk = 1'b0;
  logic        rst_pin_n = 1'b0;
  logic [9:0]  strap_lvl = '0;
  logic        pin_fde = 1'b0, pin_cfg0 = 1'b0, pin_cfg1 = 1'b0, pin_lock = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  phy_addr;
  logic [15:0] ctrl_reg, adv_reg, mode_reg;
  logic        core_rst;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  strap_cfg_ctrl #(.EXT_CYCLES(EXT)) uut (
    .clk(clk), .rst_pin_n(rst_pin_n), .strap_lvl(strap_lvl),
    .pin_fde(pin_fde), .pin_cfg0(pin_cfg0), .pin_cfg1(pin_cfg1), .pin_lock(pin_lock),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .phy_addr(phy_addr), .ctrl_reg(ctrl_reg), .adv_reg(adv_reg),
    .mode_reg(mode_reg), .core_rst(core_rst)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [14:0] m_d1 = '0, m_d2 = '0;   // pin history, two edges deep
  int          m_cnt = 0;
  bit          m_prev = 0;
  bit [4:0]    m_addr;
  bit          m_loop, m_speed, m_anen, m_pdn, m_iso, m_restart, m_duplex;
  bit [3:0]    m_adv;
  bit [4:0]    m_mode;
  int          low_seen = 0;
  bit          m_valid = 0;

  function automatic bit mbit(input logic [9:0] l, input int i);
    int code;
    code = int'(l[2*i +: 2]);
    return (code == 1) || (code == 2);
  endfunction

  task automatic take_defaults(input logic [9:0] l, input bit c0, input bit c1, input bit fd);
    bit an, med, full;
    an  = mbit(l, 0);
    med = mbit(l, 4);
    full = !c1 || fd;
    m_anen   = an;
    m_speed  = an ? 1'b1 : c0;
    m_duplex = an ? 1'b0 : fd;
    m_mode   = {an ? 1'b0 : c1, an ? 1'b0 : med, mbit(l, 3), mbit(l, 2), mbit(l, 1)};
    m_adv    = {!med && full, !med, (!c1 || med) && full, !c1 || med};
  endtask

  always @(posedge clk) begin
    bit rel, lk, c1, c0, fd, in_rst, ok, kick, an_now;
    logic [9:0] lvq;
    {rel, lk, c1, c0, fd, lvq} = m_d2;
    in_rst = (m_cnt != 0);
    an_now = m_anen;
    ok   = wr_en && !lk && !in_rst;
    kick = ok && (wr_addr == 5'd0) && wr_data[15];
    if (in_rst) begin
      take_defaults(lvq, c0, c1, fd);
      m_addr = {lvq[9], lvq[7], lvq[5], lvq[3], lvq[1]};
      m_loop = 0; m_pdn = 0; m_iso = 0; m_restart = 0;
    end else begin
      if (lk) take_defaults(lvq, c0, c1, fd);
      else if (ok && !kick) begin
        if (wr_addr == 5'd0) begin
          m_loop = wr_data[14]; m_speed = wr_data[13]; m_anen = wr_data[12];
          m_pdn = wr_data[11]; m_iso = wr_data[10]; m_restart = wr_data[9];
          m_duplex = wr_data[8];
        end else if (wr_addr == 5'd4) m_adv = wr_data[8:5];
        else if (wr_addr == 5'd16) m_mode = wr_data[4:0];
      end
      if (an_now && c0 && !m_prev) m_restart = 1;
    end
    if (!rel || kick) m_cnt = EXT;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    m_prev = c0;
    m_d2 = m_d1;
    m_d1 = {rst_pin_n, pin_lock, pin_cfg1, pin_cfg0, pin_fde, strap_lvl};
    if (!rst_pin_n) low_seen++;
    if (low_seen >= 5) m_valid = 1;
    #1;
    if (m_valid) begin
      chk("R1 phy_addr", {11'd0, phy_addr}, {11'd0, m_addr});
      chk("R8 core_rst/ctrl[15]", {14'd0, core_rst, ctrl_reg[15]},
          {14'd0, m_cnt != 0, m_cnt != 0});
      chk("R2 ctrl[12]", {15'd0, ctrl_reg[12]}, {15'd0, m_anen});
      chk("R3 ctrl[13],ctrl[8]", {14'd0, ctrl_reg[13], ctrl_reg[8]}, {14'd0, m_speed, m_duplex});
      chk("R7 ctrl[9]", {15'd0, ctrl_reg[9]}, {15'd0, m_restart});
      chk("R6 ctrl[14,11,10]", {13'd0, ctrl_reg[14], ctrl_reg[11], ctrl_reg[10]},
          {13'd0, m_loop, m_pdn, m_iso});
      chk("R10 ctrl[7:0]", {8'd0, ctrl_reg[7:0]}, 16'h0000);
      chk("R4 adv_reg", adv_reg, {7'd0, m_adv, 5'b00001});
      chk("R2 R3 mode_reg", mode_reg, {11'd0, m_mode});
    end
  end

  // ---------------- stimulus ----------------
  task automatic mwrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // straps s4..s0 = 0,1,3,0,2
    strap_lvl = 10'b00_01_11_00_10;
    pin_fde = 1; pin_cfg0 = 0; pin_cfg1 = 0; pin_lock = 0;
    rst_pin_n = 0;
    idle(8);
    chk("R8 held while pin low", {15'd0, core_rst}, 16'h0001);
    rst_pin_n = 1;
    idle(EXT + 1);
    chk("R8 still stretched one edge before end", {15'd0, core_rst}, 16'h0001);
    idle(1);
    chk("R8 released after EXT+2 edges", {15'd0, core_rst}, 16'h0000);
    chk("R1 address from straps", {11'd0, phy_addr}, 16'h0005);
    chk("R2 R3 control defaults, negotiation on", ctrl_reg, 16'h3000);
    chk("R4 all four abilities", adv_reg, 16'h01E1);
    chk("R2 mode defaults", mode_reg, 16'h0004);

    // R6: pin change without lock ignored
    strap_lvl = 10'b00_01_11_01_10;
    idle(5);
    chk("R6 strap change ignored when unlocked", mode_reg, 16'h0004);

    // R7: restart edge with negotiation on
    pin_cfg0 = 1;
    idle(4);
    chk("R7 restart set by rising edge", ctrl_reg, 16'h3200);

    // R6 writes
    mwrite(5'd0, 16'h4100);
    chk("R6 control write", ctrl_reg, 16'h4100);
    mwrite(5'd4, 16'h0020);
    chk("R6 advert write", adv_reg, 16'h0021);
    mwrite(5'd16, 16'h001F);
    chk("R6 mode write", mode_reg, 16'h001F);
    mwrite(5'd7, 16'hFFFF);
    chk("R10 other address ctrl", ctrl_reg, 16'h4100);
    chk("R10 other address adv", adv_reg, 16'h0021);
    mwrite(5'd4, 16'hFFFF);
    chk("R10 only ability bits written", adv_reg, 16'h01E1);

    // R7: edge with negotiation off does nothing
    pin_cfg0 = 0; idle(4);
    pin_cfg0 = 1; idle(4);
    chk("R7 no restart with negotiation off", ctrl_reg, 16'h4100);

    // R9 software reset, R10 write during reset
    mwrite(5'd0, 16'h8000);
    chk("R9 soft reset raises core_rst", {15'd0, core_rst}, 16'h0001);
    mwrite(5'd0, 16'h4000);
    idle(EXT + 2);
    chk("R9 defaults reloaded", ctrl_reg, 16'h3000);
    chk("R9 mode reloaded from current straps", mode_reg, 16'h0005);
    chk("R10 write during reset dropped", {15'd0, ctrl_reg[14]}, 16'h0000);

    // R5 locked, continuous
    pin_lock = 1;
    strap_lvl = 10'b10_01_11_01_00;
    pin_fde = 1; pin_cfg0 = 1; pin_cfg1 = 1;
    idle(5);
    chk("R5 R3 locked control follows pins", ctrl_reg, 16'h2100);
    chk("R4 ten-only abilities", adv_reg, 16'h0061);
    chk("R3 fiber and link-test from pins", mode_reg, 16'h001D);
    mwrite(5'd0, 16'h4000);
    chk("R5 write refused", ctrl_reg, 16'h2100);
    mwrite(5'd0, 16'h8000);
    chk("R5 soft reset refused", {15'd0, core_rst}, 16'h0000);
    pin_fde = 0;
    idle(4);
    chk("R5 duplex follows pin", ctrl_reg, 16'h2000);
    chk("R4 half only", adv_reg, 16'h0021);
    chk("R1 address held after strap change", {11'd0, phy_addr}, 16'h0005);

    // R7 in locked mode
    strap_lvl = 10'b10_01_11_01_10;
    pin_cfg0 = 0; idle(4);
    pin_cfg0 = 1; idle(4);
    chk("R7 restart in locked mode", ctrl_reg, 16'h3200);

    // second pin reset
    rst_pin_n = 0; idle(4);
    rst_pin_n = 1; idle(EXT + 4);
    chk("R1 address recaptured", {11'd0, phy_addr}, 16'h0015);
    chk("R8 restart cleared by reset", ctrl_reg, 16'h3000);

    idle(3);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R8: run did not finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule